// File: doc/BRIEF.md
# Paper Tape Word Assembler

This block sits between an eight-hole paper tape reader and a 36-bit in-out register. The reader offers one tape line at a time with a single-cycle strobe. A request together with a mode code starts one of three operations. In character mode the next line is returned as a whole. In word mode six qualifying lines are packed into one 36-bit word. In boot mode words are gathered without end, and each pair is read as a command followed by an operand. This fills memory straight from tape, and the pass ends when a jump command names the address where the processor should begin.

Holes are numbered 1 to 8 from `tape_line[0]` to `tape_line[7]`. In word and boot modes, a line counts only if hole 8 is punched. Hole 7 is a don't-care. Holes 1 to 6 supply six data bits. A finished operation in character or word mode gives a one-cycle completion pulse, and the word stays on `rd_word` after it. Boot mode drives a memory write port. It also holds a run request with a start address until the processor acknowledges it.

The controller is a single state machine with six states:
- `ST_IDLE` waits for a request.
- `ST_ALPHA` waits for one line.
- `ST_BIN` packs one word.
- `ST_BOOT_CMD` packs and decodes a command word.
- `ST_BOOT_DATA` packs an operand word and writes it to memory.
- `ST_BOOT_RUN` holds the run request.

The transitions are:
- `ST_IDLE` goes to `ST_ALPHA`, `ST_BIN` or `ST_BOOT_CMD` on an accepted request with mode 0, 1 or 2. Mode 3 leaves it idle.
- `ST_ALPHA` goes to `ST_IDLE` on any strobe.
- `ST_BIN` goes to `ST_IDLE` when the word completes.
- `ST_BOOT_CMD` goes to `ST_BOOT_DATA` on a deposit command, to `ST_BOOT_RUN` on a jump command, and to `ST_IDLE` on any other operation code.
- `ST_BOOT_DATA` goes back to `ST_BOOT_CMD` once its word is written.
- `ST_BOOT_RUN` goes to `ST_IDLE` on `run_ack`.

Top module: `tape_word_assembler`

## Requirements
- R1: While reset is held and just after it, `rd_done`, `mem_we`, `run_req` and `boot_err` are 0, and `rd_word` is zero.
- R2: Mode 0 (character) takes the first strobed line after the request. `rd_word` becomes that line in bits 7:0 with bits 35:8 cleared, and `rd_done` pulses in the cycle after the strobe. The line needs no hole 8, and further lines without a new request are not taken.
- R3: Mode 1 (word) packs six qualifying lines. The first line fills bits 35:30 and each later line fills the next lower 6-bit group, with hole 1 as the LSB of its group. `rd_done` pulses for one cycle, in the cycle after the sixth qualifying strobe.
- R4: In modes 1 and 2, a line with hole 8 (bit 7) clear is discarded and does not count toward the six.
- R5: In modes 1 and 2, hole 7 (bit 6) has no effect on the packed word.
- R6: In mode 2, the first word and every second word after it are commands. A command whose bits 35:30 equal octal 32 is a deposit, and its address is bits 14:0. The next word is written with one `mem_we` pulse in the cycle after its sixth qualifying strobe, with `mem_addr` set to that address and `mem_wdata` set to the word. Boot mode never pulses `rd_done`.
- R7: In mode 2, a command whose bits 35:30 equal octal 60 ends boot mode. `run_req` rises in the cycle after the command's last strobe, with `run_addr` set to bits 14:0. Both hold until `run_ack` is sampled high, and no memory write follows.
- R8: In mode 2, a command with any other operation code sets `boot_err` and returns to idle with no memory write. `boot_err` clears when the next request is accepted.
- R9: A strobe while idle or while the run request is pending has no effect. A request while an operation is in progress is ignored.
- R10: Strobes on consecutive cycles are all taken. This includes a strobe in the same cycle as a `mem_we` pulse, which counts toward the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Start request, taken only when idle |
| rd_mode | input | 2 | 0 character, 1 word, 2 boot |
| tape_strobe | input | 1 | One-cycle pulse: tape_line holds a line |
| tape_line | input | 8 | Tape line, bit k is hole k+1 |
| rd_done | output | 1 | Completion pulse in modes 0 and 1 |
| rd_word | output | 36 | Last character or word delivered |
| mem_we | output | 1 | Memory write pulse in boot mode |
| mem_addr | output | 15 | Memory write address |
| mem_wdata | output | 36 | Memory write data |
| run_req | output | 1 | Request to start execution |
| run_addr | output | 15 | Start address for execution |
| run_ack | input | 1 | Processor has taken the start address |
| boot_err | output | 1 | Boot command had an unknown operation code |

## Verification
The memory write of a finished operand word can land in the same cycle as the first line of the next command word. The bench provokes this by keeping the strobe high without a gap across five words in boot mode. It then judges both words together: each write must show its own command's address and the full operand, and the command straddling the write must still decode to the right address. A second collision, a request arriving in the middle of a word, is judged by the completion pulse appearing only after the sixth qualifying line and not earlier.

// File: rtl/tape_rdr_pkg.sv
package tape_rdr_pkg;

    // request mode codes on rd_mode
    localparam logic [1:0] MODE_ALPHA = 2'd0;
    localparam logic [1:0] MODE_BIN   = 2'd1;
    localparam logic [1:0] MODE_BOOT  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALPHA,
        ST_BIN,
        ST_BOOT_CMD,
        ST_BOOT_DATA,
        ST_BOOT_RUN
    } rdr_state_e;

endpackage

// File: rtl/tape_group_packer.sv
module tape_group_packer #(
    parameter int WORD_W  = 36,
    parameter int GROUP_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               strobe,
    input  logic               mark,
    input  logic [GROUP_W-1:0] grp,
    output logic               word_done,
    output logic [WORD_W-1:0]  word_val
);
    localparam int LINES = WORD_W / GROUP_W;
    localparam int CNT_W = (LINES > 1) ? $clog2(LINES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LINES - 1);

    logic [WORD_W-1:0] acc;
    logic [CNT_W-1:0]  cnt;
    logic              take;

    // only lines carrying the framing hole are counted
    assign take      = strobe && mark;
    assign word_done = take && (cnt == LAST);

    generate
        if (WORD_W > GROUP_W) begin : g_shift
            assign word_val = {acc[WORD_W-GROUP_W-1:0], grp};
        end else begin : g_single
            assign word_val = grp;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc <= '0;
            cnt <= '0;
        end else if (take) begin
            acc <= word_val;
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R4
    unmarked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !mark && !clear) |=> $stable(cnt));

endmodule

// File: rtl/boot_cmd_decode.sv
module boot_cmd_decode #(
    parameter int              OP_W       = 6,
    parameter logic [OP_W-1:0] OP_DEPOSIT = 6'o32,
    parameter logic [OP_W-1:0] OP_JUMP    = 6'o60
) (
    input  logic [OP_W-1:0] opcode,
    output logic            is_deposit,
    output logic            is_jump
);
    assign is_deposit = (opcode == OP_DEPOSIT);
    assign is_jump    = (opcode == OP_JUMP);

    // R6
    always_comb begin
        excl_cmd_chk: assert (!(is_deposit && is_jump));
    end

endmodule

// File: rtl/tape_word_assembler.sv
module tape_word_assembler
    import tape_rdr_pkg::*;
#(
    parameter int              WORD_W     = 36,
    parameter int              LINE_W     = 8,
    parameter int              GROUP_W    = 6,
    parameter int              ADDR_W     = 15,
    parameter int              OP_W       = 6,
    parameter logic [OP_W-1:0] OP_DEPOSIT = 6'o32,
    parameter logic [OP_W-1:0] OP_JUMP    = 6'o60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [1:0]        rd_mode,
    input  logic              tape_strobe,
    input  logic [LINE_W-1:0] tape_line,
    output logic              rd_done,
    output logic [WORD_W-1:0] rd_word,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              run_req,
    output logic [ADDR_W-1:0] run_addr,
    input  logic              run_ack,
    output logic              boot_err
);
    localparam int PAD_W = WORD_W - LINE_W;

    rdr_state_e state, state_nx;

    logic              req_ok;
    logic              pack_on;
    logic              word_done;
    logic [WORD_W-1:0] word_val;
    logic              is_dep;
    logic              is_jmp;

    assign req_ok  = rd_req && (state == ST_IDLE);
    assign pack_on = tape_strobe &&
                     (state == ST_BIN || state == ST_BOOT_CMD || state == ST_BOOT_DATA);

    tape_group_packer #(
        .WORD_W  (WORD_W),
        .GROUP_W (GROUP_W)
    ) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (req_ok),
        .strobe    (pack_on),
        .mark      (tape_line[LINE_W-1]),
        .grp       (tape_line[GROUP_W-1:0]),
        .word_done (word_done),
        .word_val  (word_val)
    );

    boot_cmd_decode #(
        .OP_W       (OP_W),
        .OP_DEPOSIT (OP_DEPOSIT),
        .OP_JUMP    (OP_JUMP)
    ) u_decode (
        .opcode     (word_val[WORD_W-1 -: OP_W]),
        .is_deposit (is_dep),
        .is_jump    (is_jmp)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (rd_req) begin
                    if (rd_mode == MODE_ALPHA)     state_nx = ST_ALPHA;
                    else if (rd_mode == MODE_BIN)  state_nx = ST_BIN;
                    else if (rd_mode == MODE_BOOT) state_nx = ST_BOOT_CMD;
                end
            end
            ST_ALPHA:     if (tape_strobe) state_nx = ST_IDLE;
            ST_BIN:       if (word_done)   state_nx = ST_IDLE;
            ST_BOOT_CMD: begin
                if (word_done) begin
                    if (is_dep)      state_nx = ST_BOOT_DATA;
                    else if (is_jmp) state_nx = ST_BOOT_RUN;
                    else             state_nx = ST_IDLE;
                end
            end
            ST_BOOT_DATA: if (word_done) state_nx = ST_BOOT_CMD;
            ST_BOOT_RUN:  if (run_ack)   state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_done   <= 1'b0;
            rd_word   <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            run_req   <= 1'b0;
            run_addr  <= '0;
            boot_err  <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            mem_we  <= 1'b0;
            if (req_ok) boot_err <= 1'b0;
            unique case (state)
                ST_ALPHA: begin
                    if (tape_strobe) begin
                        rd_word <= {{PAD_W{1'b0}}, tape_line};
                        rd_done <= 1'b1;
                    end
                end
                ST_BIN: begin
                    if (word_done) begin
                        rd_word <= word_val;
                        rd_done <= 1'b1;
                    end
                end
                ST_BOOT_CMD: begin
                    if (word_done) begin
                        if (is_dep) begin
                            mem_addr <= word_val[ADDR_W-1:0];
                        end else if (is_jmp) begin
                            run_addr <= word_val[ADDR_W-1:0];
                            run_req  <= 1'b1;
                        end else begin
                            boot_err <= 1'b1;
                        end
                    end
                end
                ST_BOOT_DATA: begin
                    if (word_done) begin
                        mem_wdata <= word_val;
                        mem_we    <= 1'b1;
                    end
                end
                ST_BOOT_RUN: begin
                    if (run_ack) run_req <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    // R6
    write_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == ST_BOOT_CMD) && !rd_done);

    // R7
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_req && !run_ack) |=> run_req && $stable(run_addr));

    // R8
    err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |-> !mem_we && !run_req);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> !rd_done && !mem_we);

endmodule

// File: tb/test_tape_word_assembler.sv
`timescale 1ns/100ps
module test_tape_word_assembler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [1:0]  rd_mode = 2'd0;
    logic        tape_strobe = 1'b0;
    logic [7:0]  tape_line = 8'h00;
    logic        run_ack = 1'b0;
    logic        rd_done;
    logic [35:0] rd_word;
    logic        mem_we;
    logic [14:0] mem_addr;
    logic [35:0] mem_wdata;
    logic        run_req;
    logic [14:0] run_addr;
    logic        boot_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tape_word_assembler i_tape_word_assembler (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .rd_mode     (rd_mode),
        .tape_strobe (tape_strobe),
        .tape_line   (tape_line),
        .rd_done     (rd_done),
        .rd_word     (rd_word),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .run_req     (run_req),
        .run_addr    (run_addr),
        .run_ack     (run_ack),
        .boot_err    (boot_err)
    );

    // mode bit, six lines (first in the top byte), expected word
    localparam int NV = 5;
    localparam logic [84:0] VECS [NV] = '{
        {1'b0, 48'hA50000000000, 36'h0000000A5},
        {1'b0, 48'hFF0000000000, 36'h0000000FF},
        {1'b1, 48'h818283848586, 36'h0420C4146},
        {1'b1, 48'hFFFFFFFFFFFF, 36'hFFFFFFFFF},  // R5: hole 7 punched everywhere
        {1'b1, 48'hC0BF809CE381, 36'h03F01C8C1}   // R5: mixed hole 7
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic drive(input logic [7:0] d);
        tape_strobe = 1'b1;
        tape_line   = d;
        @(negedge clk);
    endtask

    task automatic idle();
        tape_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_line(input logic [7:0] d);
        drive(d);
        tape_strobe = 1'b0;
    endtask

    task automatic request(input logic [1:0] m);
        rd_req  = 1'b1;
        rd_mode = m;
        @(negedge clk);
        rd_req  = 1'b0;
    endtask

    function automatic logic [7:0] bline(input logic [35:0] w, input int k);
        return {2'b10, w[35-6*k -: 6]};
    endfunction

    task automatic drive_word(input logic [35:0] w);
        for (int k = 0; k < 6; k++) drive(bline(w, k));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [35:0] c1, d1, c2, d2, jc, bad;
        c1  = {6'o32, 15'h0000, 15'h0123};
        d1  = 36'h123456789;
        c2  = {6'o32, 15'h0000, 15'h7FFF};
        d2  = 36'hFEDCBA987;
        jc  = {6'o60, 15'h0000, 15'h0456};
        bad = {6'o20, 15'h0000, 15'h0055};

        repeat (3) @(negedge clk);
        // R1 outputs under reset
        chk("R1 done in reset", rd_done, 0);
        chk("R1 word in reset", rd_word, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mem_we after reset", mem_we, 0);
        chk("R1 run_req after reset", run_req, 0);
        chk("R1 boot_err after reset", boot_err, 0);

        // R9 strobe while idle
        send_line(8'hC7);
        chk("R9 idle strobe done", rd_done, 0);
        chk("R9 idle strobe word", rd_word, 0);

        // vector table: R2 character, R3/R5 word mode
        for (int v = 0; v < NV; v++) begin
            int nl;
            nl = VECS[v][84] ? 6 : 1;
            request({1'b0, VECS[v][84]});
            for (int k = 0; k < nl; k++) begin
                send_line(VECS[v][83-8*k -: 8]);
                if (k < nl - 1) chk("R3 early done", rd_done, 0);
            end
            chk(VECS[v][84] ? "R3 word done" : "R2 char done", rd_done, 1);
            chk(VECS[v][84] ? "R3/R5 word value" : "R2 char value", rd_word, VECS[v][35:0]);
            idle();
            chk("R2 done single cycle", rd_done, 0);
        end

        // R2 one line per request
        request(2'd0);
        send_line(8'h5A);
        chk("R2 char no hole8", rd_word, 36'h05A);
        send_line(8'h33);
        chk("R2 second line ignored done", rd_done, 0);
        chk("R2 second line ignored word", rd_word, 36'h05A);

        // R4 lines without hole 8 are skipped
        request(2'd1);
        send_line(8'h81); send_line(8'h7F); send_line(8'h82); send_line(8'h00);
        send_line(8'h83); send_line(8'h84);
        chk("R4 six strobes not six lines", rd_done, 0);
        send_line(8'h85); send_line(8'h40); send_line(8'h86);
        chk("R4 done after six marked", rd_done, 1);
        chk("R4 word value", rd_word, 36'h0420C4146);

        // R9 request while busy is ignored
        request(2'd1);
        send_line(8'h81); send_line(8'h82); send_line(8'h83);
        request(2'd0);
        send_line(8'h84);
        chk("R9 busy request ignored", rd_done, 0);
        send_line(8'h85); send_line(8'h86);
        chk("R9 busy word done", rd_done, 1);
        chk("R9 busy word value", rd_word, 36'h0420C4146);

        // R6 R7 R10 boot with strobes back to back
        request(2'd2);
        drive_word(c1);
        chk("R6 no write on command", mem_we, 0);
        drive_word(d1);
        chk("R6 write pulse", mem_we, 1);
        chk("R6 write addr", mem_addr, 15'h0123);
        chk("R6 write data", mem_wdata, d1);
        chk("R6 no done in boot", rd_done, 0);
        drive_word(c2);   // R10: first line shares the write cycle
        chk("R10 write single pulse", mem_we, 0);
        drive_word(d2);
        chk("R10 second write pulse", mem_we, 1);
        chk("R10 second write addr", mem_addr, 15'h7FFF);
        chk("R10 second write data", mem_wdata, d2);
        drive_word(jc);
        chk("R7 run request", run_req, 1);
        chk("R7 run addr", run_addr, 15'h0456);
        chk("R7 no write on jump", mem_we, 0);
        idle();
        send_line(8'h81);
        chk("R9 strobe while run pending", mem_we, 0);
        chk("R7 run held", run_req, 1);
        chk("R7 addr held", run_addr, 15'h0456);
        run_ack = 1'b1;
        @(negedge clk);
        run_ack = 1'b0;
        chk("R7 run released", run_req, 0);

        // R8 unknown command
        request(2'd2);
        drive_word(bad);
        chk("R8 error set", boot_err, 1);
        chk("R8 no write", mem_we, 0);
        for (int k = 0; k < 6; k++) begin
            drive(bline(d1, k));
            chk("R8 no write after error", mem_we, 0);
        end
        idle();
        chk("R8 no run after error", run_req, 0);
        request(2'd0);
        chk("R8 error cleared by request", boot_err, 0);
        send_line(8'h41);
        chk("R8 char after error", rd_word, 36'h041);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule